// File: doc/BRIEF.md
# Sample-Rate Strobe Down-Counter with Deferred Period Update

This block produces the latch strobe that tells a decimation filter when one sample interval has ended. A down-counter runs on the fast modulator-side clock, which is four times the filter rate, so useful period values have the form 4·M − 1 for a decimation ratio M. When the count passes zero the block emits a one-cycle strobe and reloads the count. One interval therefore lasts period + 1 clock cycles.

A controller loads the 16-bit period as two byte writes: the upper byte first, then the lower byte. The lower-byte write commits the whole value. How a commit acts depends on whether the counter is running. While the counter is stopped, the value loads straight into both the period and the count. While the counter is running, the value is held in a shadow register and applied only at the next wrap. This lets a controller load a short settling interval, start the counter, and then write the full interval at once. The short interval then flushes the previous conversion and is followed by full intervals with no timing-critical second write.

Top module: `smp_strobe_gen`

## Requirements
- R1: After reset, the period readback, the count readback and the strobe are all zero.
- R2: With the counter stopped, a lower-byte write commits {staged upper byte, written lower byte}. On the next cycle, both the period readback and the count readback show this value.
- R3: With the counter running, a committed value goes only to the shadow register. The period readback keeps its value and the count keeps decrementing until the next wrap.
- R4: While running, the count drops by one per clock. A clock edge at which the count is zero reloads the count and the period from the shadow register and raises the strobe for exactly that following cycle. A period P gives a strobe every P + 1 cycles, with the first strobe P + 1 edges after counting starts from a count of P.
- R5: An upper-byte write only stages the byte. The period and the count do not change until a lower-byte write commits it.
- R6: With the run input low, the count holds and no strobe appears. When run returns high, counting resumes from the held count.
- R7: A period of zero gives a strobe on every cycle while running.
- R8: Loading 0x000F while stopped, then committing 0x001F as counting starts, gives a first interval of 16 cycles followed by intervals of 32 cycles.
- R9: The period readback always shows the period register, including right after a wrap that applied a shadowed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counter clock (four times the filter rate) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Counter run control |
| wr_hi_i | input | 1 | Stage the upper period byte from wdata_i |
| wr_lo_i | input | 1 | Write the lower period byte and commit the 16-bit value |
| wdata_i | input | 8 | Byte write data |
| period_o | output | 16 | Period register readback |
| count_o | output | 16 | Current count readback |
| strobe_o | output | 1 | One-cycle sample latch strobe |

## Verification
A corrupted count shows at once on count_o. At the strobe it also shifts the spacing of the wraps by the size of the error, so a sweep of interval lengths over many periods catches it within one interval. A shadow register that loads at the wrong moment shows on period_o right after the next strobe, and in the length of the following interval. A fault in the staging path shows on both readbacks one cycle after the committing lower-byte write.

// File: rtl/ssg_pkg.sv
package ssg_pkg;
  // Destination of a committed period value
  typedef enum logic [1:0] {
    TGT_NONE   = 2'd0,
    TGT_LOAD   = 2'd1,  // stopped: period and count load directly
    TGT_SHADOW = 2'd2   // running: deferred until next wrap
  } commit_tgt_e;
endpackage

// File: rtl/ssg_stage.sv
module ssg_stage #(
  parameter int unsigned PERIOD_W = 16,
  parameter int unsigned BYTE_W   = 8,
  localparam int unsigned HI_W    = PERIOD_W - BYTE_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_hi_i,
  input  logic                wr_lo_i,
  input  logic [BYTE_W-1:0]   wdata_i,
  output logic                commit_vld_o,
  output logic [PERIOD_W-1:0] commit_val_o
);
  logic [HI_W-1:0] hi_q, hi_d;

  always_comb begin
    hi_d = hi_q;
    if (wr_hi_i) hi_d = wdata_i[HI_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hi_q <= '0;
    else if (wr_hi_i) hi_q <= hi_d;
  end

  assign commit_vld_o = wr_lo_i;
  assign commit_val_o = {hi_q, wdata_i};
endmodule

// File: rtl/ssg_core.sv
module ssg_core
  import ssg_pkg::*;
#(
  parameter int unsigned PERIOD_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic                commit_vld_i,
  input  logic [PERIOD_W-1:0] commit_val_i,
  output logic [PERIOD_W-1:0] period_o,
  output logic [PERIOD_W-1:0] count_o,
  output logic                strobe_o
);
  logic [PERIOD_W-1:0] cnt_q, cnt_d, per_q, per_d, shd_q, shd_d;
  logic                stb_q, stb_d;
  logic                wrap;
  logic                reg_en;
  commit_tgt_e         tgt;

  assign wrap   = run_i && (cnt_q == '0);
  assign reg_en = run_i | commit_vld_i;

  always_comb begin
    if (!commit_vld_i) tgt = TGT_NONE;
    else if (run_i)    tgt = TGT_SHADOW;
    else               tgt = TGT_LOAD;
  end

  always_comb begin
    cnt_d = cnt_q;
    per_d = per_q;
    shd_d = shd_q;
    stb_d = 1'b0;
    if (run_i) begin
      if (wrap) begin
        cnt_d = shd_q;
        per_d = shd_q;
        stb_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
    case (tgt)
      TGT_SHADOW: shd_d = commit_val_i;
      TGT_LOAD: begin
        per_d = commit_val_i;
        cnt_d = commit_val_i;
        shd_d = commit_val_i;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      per_q <= '0;
      shd_q <= '0;
    end else if (reg_en) begin
      cnt_q <= cnt_d;
      per_q <= per_d;
      shd_q <= shd_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stb_q <= 1'b0;
    else         stb_q <= stb_d;
  end

  assign period_o = per_q;
  assign count_o  = cnt_q;
  assign strobe_o = stb_q;

  // R2
  stopped_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && commit_vld_i) |=> (count_o == period_o));
  // R4
  countdown_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && count_o != '0) |=> (count_o == $past(count_o) - 1'b1));
  // R4
  wrap_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> (count_o == period_o));
  // R6
  frozen_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !commit_vld_i) |=> $stable(count_o));
  // R6
  no_idle_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !strobe_o);
endmodule

// File: rtl/smp_strobe_gen.sv
module smp_strobe_gen #(
  parameter int unsigned PERIOD_W = 16,
  parameter int unsigned BYTE_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic                wr_hi_i,
  input  logic                wr_lo_i,
  input  logic [BYTE_W-1:0]   wdata_i,
  output logic [PERIOD_W-1:0] period_o,
  output logic [PERIOD_W-1:0] count_o,
  output logic                strobe_o
);
  logic                commit_vld;
  logic [PERIOD_W-1:0] commit_val;

  ssg_stage #(.PERIOD_W(PERIOD_W), .BYTE_W(BYTE_W)) i_stage (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_hi_i      (wr_hi_i),
    .wr_lo_i      (wr_lo_i),
    .wdata_i      (wdata_i),
    .commit_vld_o (commit_vld),
    .commit_val_o (commit_val)
  );

  ssg_core #(.PERIOD_W(PERIOD_W)) i_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (run_i),
    .commit_vld_i (commit_vld),
    .commit_val_i (commit_val),
    .period_o     (period_o),
    .count_o      (count_o),
    .strobe_o     (strobe_o)
  );
endmodule

// File: tb/test_smp_strobe_gen.sv
module test_smp_strobe_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        wr_hi = 1'b0;
  logic        wr_lo = 1'b0;
  logic [7:0]  wdata = '0;
  logic [15:0] period_o, count_o;
  logic        strobe_o;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  smp_strobe_gen i_smp_strobe_gen (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .wr_hi_i(wr_hi),
    .wr_lo_i(wr_lo), .wdata_i(wdata), .period_o(period_o),
    .count_o(count_o), .strobe_o(strobe_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_byte(input bit hi, input logic [7:0] d);
    @(negedge clk);
    wr_hi = hi; wr_lo = !hi; wdata = d;
    @(negedge clk);
    wr_hi = 1'b0; wr_lo = 1'b0;
  endtask

  task automatic load(input logic [15:0] v);
    wr_byte(1'b1, v[15:8]);
    wr_byte(1'b0, v[7:0]);
  endtask

  // Counts edges from now until strobe_o is seen high (sampled after edge)
  task automatic wait_strobe(output int n);
    n = 0;
    do begin
      @(posedge clk); #1; n++;
    end while (!strobe_o && n < 70000);
  endtask

  initial begin
    int n;
    int c0;
    #55 rst_n = 1'b1;
    @(negedge clk);
    check("R1 period", period_o, 0);
    check("R1 count", count_o, 0);
    check("R1 strobe", strobe_o, 0);

    // Sweep of small periods plus two full-size ones
    for (int k = 0; k < 23; k++) begin
      int p;
      p = (k < 21) ? k : ((k == 21) ? 16'h01FF : 471);
      load(p[15:0]);
      check("R2 period", period_o, p);
      check("R2 count", count_o, p);
      @(negedge clk); run = 1'b1;
      wait_strobe(n);
      check(p == 0 ? "R7 first" : "R4 first", n, p + 1);
      check("R9 readback", period_o, p);
      wait_strobe(n);
      check(p == 0 ? "R7 next" : "R4 next", n, p + 1);
      @(negedge clk); run = 1'b0;
      @(negedge clk);
    end

    // Staging of the upper byte (R5)
    load(16'h0010);
    wr_byte(1'b1, 8'hAB);
    check("R5 period held", period_o, 16'h0010);
    check("R5 count held", count_o, 16'h0010);
    wr_byte(1'b0, 8'hCD);
    check("R5 commit", period_o, 16'hABCD);

    // Short then full sequence (R8, R3)
    load(16'h000F);
    wr_byte(1'b1, 8'h00);
    @(negedge clk);
    run = 1'b1; wr_lo = 1'b1; wdata = 8'h1F;
    @(posedge clk); #1;
    check("R3 period unchanged", period_o, 16'h000F);
    check("R3 count runs", count_o, 16'h000E);
    @(negedge clk); wr_lo = 1'b0;
    wait_strobe(n);
    check("R8 short interval", n + 1, 16);
    check("R9 shadow applied", period_o, 16'h001F);
    wait_strobe(n);
    check("R8 full interval", n, 32);
    wait_strobe(n);
    check("R8 full interval again", n, 32);
    @(negedge clk); run = 1'b0;

    // Freeze and resume (R6)
    load(16'd50);
    @(negedge clk); run = 1'b1;
    repeat (10) @(negedge clk);
    run = 1'b0;
    c0 = count_o;
    check("R6 count after 10", c0, 40);
    n = 0;
    repeat (20) begin
      @(posedge clk); #1;
      if (strobe_o) n++;
    end
    check("R6 held", count_o, 40);
    check("R6 no strobe", n, 0);
    @(negedge clk); run = 1'b1;
    wait_strobe(n);
    check("R6 resume", n, 41);
    @(negedge clk); run = 1'b0;

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk); cyc++;
    end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule